// File: doc/BRIEF.md
# Masked Configuration Register Space

This block holds the 256-byte configuration register space of one bus function. A single access port reads or writes 1, 2 or 4 bytes at any byte address, aligned or not. Every byte carries a write mask that is fixed at elaboration. A written byte keeps its read-only bits and takes new values only in its writable bits. The masks come from a few fixed header fields and from the power-of-two sizes of up to six address-window registers plus one expansion-ROM register. Those sizes and the window type codes are parameters.

Writes that run past the top of the space are cut short. Reads that would run past the top fall back to a narrower width. A write that actually changes a window register byte, or flips the memory-enable or IO-enable bit of the command byte, raises a one-cycle `remap` pulse. Downstream decode logic uses that pulse to reload its address windows. Reads return zero-extended little-endian data one cycle after the strobe.

Top module: `cfgspace_regfile`

## Requirements
- R1: A write stores, in each byte it covers, (old AND NOT mask) OR (new AND mask), using that byte's own write mask. Read-only bits keep their value.
- R2: `acc_size` gives the length: 0 means 1 byte, 1 means 2 bytes, 2 and 3 mean 4 bytes. A write at address A fills bytes A, A+1, ... from `wr_data` bits 7:0 upward. Bytes that would lie above offset 255 are dropped, with no wrap to offset 0.
- R3: In the header below offset 0x40, only these bits are writable: bits 2:0 of the command byte at 0x04 (IO enable = bit 0, memory enable = bit 1, bus master = bit 2), all of byte 0x0C, and all of byte 0x3C. The window and ROM registers are covered by R5. Every other header byte, including 0x05 and bits 7:3 of 0x04, is read-only.
- R4: Every byte from 0x40 to 0xFF is fully writable.
- R5: Window register k (k = 0..5) is the little-endian dword at 0x10+4k, and its mask is NOT(size-1). The ROM register is the dword at 0x30, and its mask is NOT(size-1) OR 1. A register whose size parameter is 0 is entirely read-only.
- R6: A read uses 4 bytes only when the 4-byte length is requested and the address is at most 0xFC. It falls back to 2 bytes when 2 or more bytes are requested and the address is at most 0xFE. Otherwise it uses 1 byte. Data is little-endian and zero-extended to 32 bits.
- R7: `rd_valid` is high exactly in the cycle after a cycle with `rd_en` high, and `rd_data` is valid then. When a read and a write share a cycle, the read returns the contents from before that write.
- R8: `remap` is high for exactly the one cycle after a write that changes any byte from 0x10 to 0x27, or changes bit 0 or bit 1 of byte 0x04. A write that changes nothing in those places, such as a write that only changes bit 2 of 0x04, gives no pulse.
- R9: After reset, `rd_valid` and `remap` are low. Each implemented window or ROM register holds its type code in its low bits with the address bits zero. Every other byte is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| acc_addr | input | 8 | Byte address of the access |
| acc_size | input | 2 | Length code: 0 = 1 byte, 1 = 2 bytes, 2/3 = 4 bytes |
| wr_data | input | 32 | Write data, lowest address in bits 7:0 |
| rd_data | output | 32 | Read data, zero-extended |
| rd_valid | output | 1 | Read data valid, one cycle after `rd_en` |
| remap | output | 1 | One-cycle pulse after a mapping-relevant change |

## Verification
The bench builds the block with six window sizes chosen to reach every shape of mask:
- a 256-byte memory window, which has a fully read-only low byte;
- a 32-byte IO window, which splits a byte between read-only and writable bits;
- a 4 KiB prefetchable window, whose writable bits start in the middle of byte 1;
- a 4-byte IO window, which is the smallest possible;
- an unimplemented slot, which is entirely read-only;
- a 2 GiB window, which leaves only bit 31 writable.

A 2 KiB ROM brings in the extra writable enable bit. With these values, a write of all ones followed by a read-back exposes every mask boundary. The top-of-space accesses at 0xFC to 0xFF exercise the read fallbacks and the dropped write bytes.

// File: rtl/cfgspace_pkg.sv
package cfgspace_pkg;
  // Six address-window slots plus the expansion ROM slot.
  localparam int NSLOT    = 7;
  localparam int ROM_SLOT = 6;
  localparam int SLOT_VEC = NSLOT * 32;

  localparam int CMD_OFF   = 'h04;
  localparam int CLS_OFF   = 'h0C;
  localparam int BAR_LO    = 'h10;
  localparam int BAR_HI    = 'h28;  // exclusive end of window registers
  localparam int ROM_LO    = 'h30;
  localparam int ROM_HI    = 'h34;
  localparam int ILINE_OFF = 'h3C;
  localparam int DEV_BASE  = 'h40;

  localparam logic [7:0] CMD_WMASK   = 8'h07;
  localparam logic [7:0] CMD_MAPBITS = 8'h03;

  function automatic int slot_of(int a);
    if (a >= BAR_LO && a < BAR_HI) return (a - BAR_LO) / 4;
    if (a >= ROM_LO && a < ROM_HI) return ROM_SLOT;
    return -1;
  endfunction

  function automatic logic [31:0] slot_wmask(int k, logic [SLOT_VEC-1:0] sz);
    logic [31:0] s;
    logic [31:0] m;
    s = sz[32*k +: 32];
    if (s == 32'd0) return 32'd0;
    m = ~(s - 32'd1);
    if (k == ROM_SLOT) m = m | 32'd1;
    return m;
  endfunction

  function automatic logic [7:0] byte_wmask(int a, logic [SLOT_VEC-1:0] sz);
    int k;
    logic [31:0] m;
    k = slot_of(a);
    if (k >= 0) begin
      m = slot_wmask(k, sz) >> (8 * (a & 3));
      return m[7:0];
    end
    if (a == CMD_OFF) return CMD_WMASK;
    if (a == CLS_OFF || a == ILINE_OFF || a >= DEV_BASE) return 8'hFF;
    return 8'h00;
  endfunction

  function automatic logic [7:0] byte_reset(int a, logic [SLOT_VEC-1:0] sz,
                                            logic [SLOT_VEC-1:0] ty);
    int k;
    logic [31:0] t;
    k = slot_of(a);
    if (k < 0) return 8'h00;
    if (sz[32*k +: 32] == 32'd0) return 8'h00;
    t = ty[32*k +: 32] >> (8 * (a & 3));
    return t[7:0];
  endfunction

  function automatic logic [2:0] size_bytes(logic [1:0] code);
    case (code)
      2'd0:    return 3'd1;
      2'd1:    return 3'd2;
      default: return 3'd4;
    endcase
  endfunction
endpackage

// File: rtl/cfgspace_wlane.sv
module cfgspace_wlane
  import cfgspace_pkg::*;
#(
  parameter int                  LANE   = 0,
  parameter int                  ADDR_W = 8,
  parameter logic [SLOT_VEC-1:0] SIZES  = '0
) (
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] base,
  input  logic [2:0]        nbytes,
  input  logic [7:0]        din,
  input  logic [7:0]        old,
  output logic              en,
  output logic [ADDR_W-1:0] addr,
  output logic [7:0]        merged,
  output logic              hit
);
  logic [ADDR_W:0] full;
  logic [7:0]      wm;

  always_comb begin
    full   = {1'b0, base} + (ADDR_W+1)'(LANE);
    addr   = full[ADDR_W-1:0];
    en     = wr_en && !full[ADDR_W] && (3'(LANE) < nbytes);
    wm     = byte_wmask(int'(addr), SIZES);
    merged = (old & ~wm) | (din & wm);
    hit    = 1'b0;
    if (en) begin
      if (int'(addr) >= BAR_LO && int'(addr) < BAR_HI)
        hit = (merged != old);
      else if (int'(addr) == CMD_OFF)
        hit = |((merged ^ old) & CMD_MAPBITS);
    end
  end
endmodule

// File: rtl/cfgspace_rdfmt.sv
module cfgspace_rdfmt #(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        size,
  input  logic [31:0]       raw,
  output logic [31:0]       data
);
  localparam int LAST = (1 << ADDR_W) - 1;

  always_comb begin
    if (size[1] && int'(addr) <= LAST - 3)
      data = raw;
    else if (size != 2'd0 && int'(addr) <= LAST - 1)
      data = {16'h0000, raw[15:0]};
    else
      data = {24'h000000, raw[7:0]};
  end
endmodule

// File: rtl/cfgspace_regfile.sv
module cfgspace_regfile
  import cfgspace_pkg::*;
#(
  parameter int                  ADDR_W      = 8,
  parameter logic [SLOT_VEC-1:0] REGION_SIZE = {32'h0, 32'h0, 32'h0, 32'h0,
                                                32'h0, 32'h100, 32'h1000},
  parameter logic [SLOT_VEC-1:0] REGION_TYPE = {32'h0, 32'h0, 32'h0, 32'h0,
                                                32'h0, 32'h1, 32'h0}
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [1:0]        acc_size,
  input  logic [31:0]       wr_data,
  output logic [31:0]       rd_data,
  output logic              rd_valid,
  output logic              remap
);
  localparam int SPACE = 1 << ADDR_W;
  localparam int LANES = 4;

  logic [7:0]        mem_q [SPACE];
  logic [31:0]       raw;
  logic [31:0]       fmt;
  logic [2:0]        nbytes;
  logic [LANES-1:0]  lane_en;
  logic [LANES-1:0]  lane_hit;
  logic [ADDR_W-1:0] lane_addr [LANES];
  logic [7:0]        lane_new  [LANES];

  assign nbytes = size_bytes(acc_size);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [ADDR_W:0] idx;
    assign idx = {1'b0, acc_addr} + (ADDR_W+1)'(g);
    // Bytes beyond the top of the space read as zero and are never written.
    assign raw[8*g +: 8] = idx[ADDR_W] ? 8'h00 : mem_q[idx[ADDR_W-1:0]];

    cfgspace_wlane #(
      .LANE   (g),
      .ADDR_W (ADDR_W),
      .SIZES  (REGION_SIZE)
    ) u_wlane (
      .wr_en  (wr_en),
      .base   (acc_addr),
      .nbytes (nbytes),
      .din    (wr_data[8*g +: 8]),
      .old    (raw[8*g +: 8]),
      .en     (lane_en[g]),
      .addr   (lane_addr[g]),
      .merged (lane_new[g]),
      .hit    (lane_hit[g])
    );
  end

  cfgspace_rdfmt #(.ADDR_W(ADDR_W)) u_rdfmt (
    .addr (acc_addr),
    .size (acc_size),
    .raw  (raw),
    .data (fmt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int j = 0; j < SPACE; j++)
        mem_q[j] <= byte_reset(j, REGION_SIZE, REGION_TYPE);
    end else begin
      for (int l = 0; l < LANES; l++)
        if (lane_en[l]) mem_q[lane_addr[l]] <= lane_new[l];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data  <= 32'h0;
      rd_valid <= 1'b0;
      remap    <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= fmt;
      remap <= wr_en && (|lane_hit);
    end
  end
endmodule

// File: rtl/cfgspace_checker.sv
module cfgspace_checker (
  input logic        clk,
  input logic        rst,
  input logic        wr_en,
  input logic        rd_en,
  input logic [1:0]  acc_size,
  input logic        rd_valid,
  input logic [31:0] rd_data,
  input logic        remap,
  input logic [7:0]  hdr_b0,
  input logic [7:0]  cmd_b
);
  p_rvalid_after_strobe_r7: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rd_valid);

  p_rvalid_needs_strobe_r7: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> $past(rd_en));

  p_remap_needs_write_r8: assert property (@(posedge clk) disable iff (rst)
    remap |-> $past(wr_en));

  p_byte_read_zero_ext_r6: assert property (@(posedge clk) disable iff (rst)
    (rd_en && acc_size == 2'd0) |=> (rd_data[31:8] == 24'h0));

  p_ro_header_byte_r3: assert property (@(posedge clk) disable iff (rst)
    $stable(hdr_b0));

  p_cmd_upper_fixed_r3: assert property (@(posedge clk) disable iff (rst)
    $stable(cmd_b[7:3]));
endmodule

bind cfgspace_regfile cfgspace_checker u_chk (
  .clk      (clk),
  .rst      (rst),
  .wr_en    (wr_en),
  .rd_en    (rd_en),
  .acc_size (acc_size),
  .rd_valid (rd_valid),
  .rd_data  (rd_data),
  .remap    (remap),
  .hdr_b0   (mem_q[0]),
  .cmd_b    (mem_q[cfgspace_pkg::CMD_OFF])
);

// File: tb/tb_cfgspace_regfile.sv
module tb_cfgspace_regfile;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;
  // slot 6 (ROM) down to slot 0
  localparam logic [223:0] SZV = {32'h800, 32'h8000_0000, 32'h0, 32'h4,
                                  32'h1000, 32'h20, 32'h100};
  localparam logic [223:0] TYV = {32'h0, 32'h0, 32'h0, 32'h1,
                                  32'h8, 32'h1, 32'h0};

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]  acc_addr = 8'h0;
  logic [1:0]  acc_size = 2'd0;
  logic [31:0] wr_data = 32'h0;
  logic [31:0] rd_data;
  logic        rd_valid, remap;

  int checks = 0, errors = 0;
  bit chk_on = 0, done = 0;
  logic [7:0]  mdl [256];
  logic        pend_rv = 0, pend_remap = 0;
  logic [31:0] pend_rd = 0;
  string       pend_tag = "R7";
  logic [31:0] lfsr = 32'hACE1_2B07;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfgspace_regfile #(.ADDR_W(8), .REGION_SIZE(SZV), .REGION_TYPE(TYV)) dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .acc_addr(acc_addr),
    .acc_size(acc_size), .wr_data(wr_data), .rd_data(rd_data),
    .rd_valid(rd_valid), .remap(remap));

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] slot_size(int k);
    return SZV[32*k +: 32];
  endfunction

  // Write mask of one byte, from the requirement text (R3, R4, R5).
  function automatic logic [7:0] bmask(int b);
    logic [31:0] s, m;
    if (b == 4) return 8'h07;
    if (b == 12 || b == 60 || b >= 64) return 8'hFF;
    if (b >= 16 && b < 40) begin
      s = slot_size((b - 16) / 4);
      m = (s == 0) ? 32'h0 : ~(s - 1);
      return m[8*(b%4) +: 8];
    end
    if (b >= 48 && b < 52) begin
      s = slot_size(6);
      m = (s == 0) ? 32'h0 : (~(s - 1) | 32'h1);
      return m[8*(b%4) +: 8];
    end
    return 8'h00;
  endfunction

  task automatic model_reset();
    for (int b = 0; b < 256; b++) mdl[b] = 8'h00;
    for (int k = 0; k < 7; k++) begin
      int base;
      logic [31:0] t;
      base = (k == 6) ? 48 : 16 + 4 * k;
      t = TYV[32*k +: 32];
      if (slot_size(k) != 0)
        for (int i = 0; i < 4; i++) mdl[base+i] = t[8*i +: 8];
    end
  endtask

  function automatic logic [31:0] model_read(int a, int sz);
    int n;
    logic [31:0] v;
    n = (sz >= 2 && a <= 252) ? 4 : ((sz >= 1 && a <= 254) ? 2 : 1);
    v = 0;
    for (int i = 0; i < n; i++) v[8*i +: 8] = mdl[a+i];
    return v;
  endfunction

  function automatic logic model_write(int a, int sz, logic [31:0] d);
    int n;
    logic rm;
    logic [7:0] nb, mk;
    n = (sz == 0) ? 1 : ((sz == 1) ? 2 : 4);
    rm = 0;
    for (int i = 0; i < n; i++) begin
      if (a + i > 255) break;
      mk = bmask(a + i);
      nb = (mdl[a+i] & ~mk) | (d[8*i +: 8] & mk);
      if (a + i >= 16 && a + i < 40 && nb != mdl[a+i]) rm = 1;
      if (a + i == 4 && ((nb ^ mdl[a+i]) & 8'h03) != 0) rm = 1;
      mdl[a+i] = nb;
    end
    return rm;
  endfunction

  task automatic cyc(bit w, bit r, int a, int sz, logic [31:0] d, string tag);
    @(negedge clk); #1;
    wr_en = w; rd_en = r; acc_addr = 8'(a); acc_size = 2'(sz); wr_data = d;
    pend_tag = tag;
    pend_rv = r;
    if (r) pend_rd = model_read(a, sz);
    pend_remap = w ? model_write(a, sz, d) : 1'b0;
  endtask

  task automatic wr(int a, int sz, logic [31:0] d, string tag);
    cyc(1, 0, a, sz, d, tag);
  endtask
  task automatic rd(int a, int sz, string tag);
    cyc(0, 1, a, sz, 32'h0, tag);
  endtask
  task automatic idle();
    cyc(0, 0, 0, 0, 32'h0, "R7");
  endtask

  // Per-cycle comparison against the model's pending expectations.
  always @(negedge clk) begin
    if (chk_on && !done) begin
      chk(rd_valid === pend_rv, "R7 rd_valid", {31'h0, rd_valid}, {31'h0, pend_rv});
      if (pend_rv) chk(rd_data === pend_rd, pend_tag, rd_data, pend_rd);
      chk(remap === pend_remap, {"R8 remap after ", pend_tag}, {31'h0, remap},
          {31'h0, pend_remap});
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL R7 watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (2) @(negedge clk);
    // R9: outputs low while reset holds
    chk(rd_valid === 1'b0 && remap === 1'b0, "R9 reset outputs",
        {30'h0, rd_valid, remap}, 32'h0);
    chk_on = 1;
    @(negedge clk); #1 rst = 0;

    // R9: reset contents of the whole space
    for (int a = 0; a < 256; a += 4) rd(a, 2, "R9");

    // R5: all-ones and all-zeros into each window and the ROM
    for (int k = 0; k < 7; k++) begin
      int base;
      base = (k == 6) ? 48 : 16 + 4 * k;
      wr(base, 2, 32'hFFFF_FFFF, "R5");
      rd(base, 2, "R5");
      wr(base, 2, 32'hFFFF_FFFF, "R8 unchanged");
      wr(base, 3, 32'h0, "R5");
      rd(base, 3, "R5");
    end

    // R1: partial masks inside bytes
    wr(16'h14, 2, 32'h1234_5678, "R1");
    rd(16'h14, 2, "R1");
    wr(16'h18, 2, 32'hA5A5_F0FF, "R1");
    rd(16'h18, 2, "R1");
    wr(16'h1C, 2, 32'hFFFF_FFFF, "R1");
    rd(16'h1C, 0, "R1");
    wr(16'h25, 1, 32'h0000_FFFF, "R1");
    rd(16'h24, 2, "R1");

    // R3 and R8: command byte
    wr(4, 0, 32'hFF, "R3");
    rd(4, 1, "R3");
    wr(4, 0, 32'hFF, "R8 no change");
    wr(4, 0, 32'hFB, "R8 bit2 only");
    rd(4, 0, "R3");
    wr(4, 0, 32'hF9, "R8 mem bit");
    wr(0, 2, 32'hFFFF_FFFF, "R3");
    rd(0, 2, "R3");
    wr(8, 2, 32'hFFFF_FFFF, "R3");
    rd(8, 2, "R3");
    wr(12, 2, 32'hFFFF_FFFF, "R3");
    rd(12, 2, "R3");
    wr(16'h3C, 2, 32'hFFFF_FFFF, "R3");
    rd(16'h3C, 2, "R3");
    wr(16'h28, 2, 32'hFFFF_FFFF, "R3");
    rd(16'h28, 2, "R3");

    // R4: device-specific area, unaligned and varied sizes
    wr(16'h41, 2, 32'hA1B2_C3D4, "R4");
    rd(16'h40, 2, "R4");
    rd(16'h42, 1, "R4");
    wr(16'h80, 1, 32'h1234_BEEF, "R4");
    rd(16'h80, 2, "R4");
    wr(16'h90, 3, 32'h0BAD_F00D, "R4");
    rd(16'h90, 3, "R4");

    // R2: lane order and end-of-space truncation
    wr(16'hFC, 2, 32'h0000_0000, "R2");
    wr(16'hFE, 2, 32'h1122_3344, "R2");
    rd(16'hFC, 2, "R2");
    wr(16'hFF, 3, 32'h5566_7788, "R2");
    rd(16'hFC, 2, "R2");
    rd(0, 2, "R2");

    // R6: read width fallback near the top
    rd(16'hFD, 2, "R6");
    rd(16'hFE, 2, "R6");
    rd(16'hFF, 2, "R6");
    rd(16'hFF, 1, "R6");
    rd(16'hFE, 1, "R6");
    rd(16'hFD, 3, "R6");
    rd(16'hFC, 3, "R6");
    rd(16'hFD, 0, "R6");

    // R7: read with write in the same cycle, back-to-back, idle gaps
    wr(16'h50, 2, 32'h1111_1111, "R7");
    cyc(1, 1, 16'h50, 2, 32'h2222_2222, "R7 read-before-write");
    rd(16'h50, 2, "R7");
    rd(16'h51, 1, "R7");
    idle();
    idle();
    rd(16'h50, 0, "R7");

    // R1: mixed traffic over the whole space
    for (int i = 0; i < 600; i++) begin
      int a, op, sz;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      op = int'(lfsr[1:0]);
      sz = int'(lfsr[3:2]);
      a  = lfsr[4] ? int'(lfsr[11:8]) + 16 * int'(lfsr[14:12] & 3'h3)
                   : int'(lfsr[23:16]);
      if (op == 3) idle();
      else cyc(op != 1, op != 0, a, sz, {lfsr[15:0], lfsr[31:16]}, "R1 mixed");
    end
    idle();
    idle();

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule